// File: doc/BRIEF.md
# Routable Timestamp Capture Units

The block holds a small set of capture units (four by default). Each unit watches one channel out of a pool of input channels (32 by default). The channel it watches is chosen at run time by a select field in a single control register. Every input channel is brought into the clock domain through a flop chain, and its rising edges are detected per channel. When the channel a unit has selected rises, the unit stores the current value of an externally supplied 32-bit timestamp counter in its own FIFO.

Software reaches the block through a simple register port with write strobe, read strobe, address and data. Address 0 is the control register. Addresses 4 up to 4 plus the unit count minus 1 are the data registers, one per unit, and a read there pops that unit's FIFO. A write to the control register loads new select fields and, in the same cycle, empties every FIFO and clears the overflow flags. Several units may watch the same channel. A unit that is switched to a channel which is already high does not record a capture.

Top module: `tscap_top`

## Requirements
- R1: While rst_n is low and after its release, rdata is 0, every FIFO is empty, every overflow flag is clear, and unit k selects channel k.
- R2: A read of address 0 returns unit k's select in bits 5k+4..5k and unit k's overflow flag in bit 20+k, with all other bits 0. A read of addresses 1, 2, 3 or of any address above the last data register returns 0.
- R3: A 0-to-1 transition on a unit's selected channel pushes one entry into that unit's FIFO. The channel must be held high for at least 3 cycles. The entry is the ts_in value present at the third rising clock edge after the transition. Falling transitions and steady levels push nothing.
- R4: Any channel can be routed to any unit. Units that select the same channel each capture the same timestamp.
- R5: A read of address 4+k returns unit k's oldest entry and removes it. Read data appears on rdata in the cycle after rd_en. In a cycle that does not follow a read, rdata is 0.
- R6: A read of an empty unit's data register returns 0 and changes nothing.
- R7: Each FIFO holds DEPTH entries (16 by default). An event that arrives while a FIFO is full is dropped, even if a pop happens in the same cycle. The dropped event sets that unit's overflow flag, and the flag stays set until the next control write.
- R8: A write to address 0 loads the select fields from wdata bits 19..0. In the same cycle it empties all FIFOs and clears all overflow flags. Events in that cycle are dropped. A read issued in the same cycle returns the state from before the write.
- R9: Changing a unit's select to a channel that is already high pushes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_in | input | 32 | Asynchronous event channels |
| ts_in | input | 32 | Shared timestamp counter value |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, one cycle after rd_en |

## Verification
The bench builds the block with a FIFO depth of 4, and all other parameters keep their defaults. The small depth makes full FIFOs, dropped events, the sticky overflow flag and full-plus-pop collisions frequent in both the directed phases and the randomised phase. The 32-channel pool and the four units stay at full size, so every select field position and every overflow bit position in the control readback is exercised. Control writes mixed randomly with reads and edges reach the same-cycle clear, read and capture orderings.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
   // register map: control word, then one data register per unit
   localparam int REG_CTRL      = 0;
   localparam int REG_DATA_BASE = 4;
   localparam int REG_W         = 32;
endpackage

// File: rtl/tscap_edge.sv
module tscap_edge #(
   parameter int N_CH   = 32,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] ch_in,
   output logic [N_CH-1:0] rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tscap_edge: STAGES must be at least 2");
   end

   logic [N_CH-1:0] stg [STAGES];
   logic [N_CH-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[s] <= '0;
         else if (s == 0) stg[s] <= ch_in;
         else             stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stg[STAGES-1];
   end

   // per-channel detection: switching a select never fabricates an edge
   assign rise = stg[STAGES-1] & ~prev_q;

   for (genvar c = 0; c < N_CH; c++) begin : g_chk
      AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         rise[c] |=> !rise[c]); // R3
   end
endmodule

// File: rtl/tscap_fifo.sv
module tscap_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full,
   output logic         ovf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("tscap_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wp_q, rp_q;
   logic         push_ok, pop_ok;

   assign empty   = (wp_q == rp_q);
   assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign push_ok = push && !full && !clr;
   assign pop_ok  = pop && !empty && !clr;
   assign dout    = mem[rp_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp_q[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
         ovf  <= 1'b0;
      end else if (clr) begin
         wp_q <= '0;
         rp_q <= '0;
         ovf  <= 1'b0;
      end else begin
         if (push_ok)     wp_q <= wp_q + 1'b1;
         if (pop_ok)      rp_q <= rp_q + 1'b1;
         if (push && full) ovf <= 1'b1;
      end
   end

   AST_FULL_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !clr) |=> ovf); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf); // R7
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (empty && !ovf)); // R8
   AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push && !clr) |=> empty); // R6
endmodule

// File: rtl/tscap_top.sv
module tscap_top
   import tscap_pkg::*;
#(
   parameter int N_UNITS     = 4,
   parameter int N_CH        = 32,
   parameter int TS_W        = 32,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_CH-1:0]   ch_in,
   input  logic [TS_W-1:0]   ts_in,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata
);
   localparam int SEL_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
   localparam int SEL_TOT = N_UNITS * SEL_W;
   localparam int OVF_LSB = SEL_TOT;

   if (SEL_TOT + N_UNITS > REG_W) begin : g_bad_fields
      $error("tscap_top: select and overflow fields exceed the register");
   end
   if (TS_W > REG_W) begin : g_bad_ts
      $error("tscap_top: TS_W wider than the register");
   end
   if ((1 << ADDR_W) < REG_DATA_BASE + N_UNITS) begin : g_bad_addr
      $error("tscap_top: ADDR_W too small for the data registers");
   end

   logic [N_CH-1:0]  rise;
   logic [SEL_W-1:0] sel_q [N_UNITS];
   logic [TS_W-1:0]  dout  [N_UNITS];
   logic [N_UNITS-1:0] empty, full, ovf, push, pop;
   logic             ctrl_wr;
   logic [REG_W-1:0] ctrl_view, rd_next;
   logic             unused_wbits;

   assign ctrl_wr      = wr_en && (addr == ADDR_W'(REG_CTRL));
   assign unused_wbits = ^wdata;

   tscap_edge #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .rise(rise)
   );

   for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sel_q[k] <= SEL_W'(k % N_CH);
         else if (ctrl_wr) sel_q[k] <= wdata[k*SEL_W +: SEL_W];
      end

      assign push[k] = rise[sel_q[k]];
      assign pop[k]  = rd_en && (addr == ADDR_W'(REG_DATA_BASE + k));

      tscap_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
         .clk(clk), .rst_n(rst_n), .clr(ctrl_wr),
         .push(push[k]), .din(ts_in), .pop(pop[k]),
         .dout(dout[k]), .empty(empty[k]), .full(full[k]), .ovf(ovf[k])
      );

      AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (pop[k] && empty[k]) |=> (rdata == '0)); // R6
      AST_READ_RETURNS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
         (pop[k] && !empty[k]) |=> (rdata == REG_W'($past(dout[k])))); // R5
   end

   always_comb begin
      ctrl_view = '0;
      for (int k = 0; k < N_UNITS; k++) begin
         ctrl_view[k*SEL_W +: SEL_W] = sel_q[k];
         ctrl_view[OVF_LSB + k]      = ovf[k];
      end
   end

   always_comb begin
      rd_next = '0;
      if (addr == ADDR_W'(REG_CTRL)) rd_next = ctrl_view;
      for (int k = 0; k < N_UNITS; k++) begin
         if (addr == ADDR_W'(REG_DATA_BASE + k) && !empty[k])
            rd_next = REG_W'(dout[k]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
      else            rdata <= '0;
   end

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0)); // R5
endmodule

// File: tb/tb_tscap_top.sv
module tb_tscap_top;
   localparam int NU = 4;
   localparam int NC = 32;
   localparam int DP = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ch_in = '0;
   logic [31:0] ts_in = 32'h1000;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string phase = "R1";

   always #5 clk = ~clk;

   tscap_top #(.N_UNITS(NU), .N_CH(NC), .TS_W(32), .DEPTH(DP),
               .SYNC_STAGES(2), .ADDR_W(3)) dut (
      .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .ts_in(ts_in),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   // ---------------- behavioural reference model ----------------
   int unsigned q [NU][$];
   int          msel [NU];
   bit          movf [NU];
   logic [31:0] m1, m2, mprev, mrdata;
   string       mtag = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NU; k++) begin
            q[k].delete(); msel[k] = k; movf[k] = 1'b0;
         end
         m1 = '0; m2 = '0; mprev = '0; mrdata = '0; mtag = "R1";
      end else begin
         logic [31:0] edges;
         logic [31:0] nxt;
         string       t;
         edges = m2 & ~mprev;
         nxt = 32'h0; t = "R5";
         if (rd_en) begin
            if (addr == 3'd0) begin
               for (int k = 0; k < NU; k++) begin
                  nxt[k*5 +: 5] = msel[k][4:0];
                  nxt[20+k]     = movf[k];
               end
               t = "R2";
            end else if (addr >= 3'd4) begin
               int u;
               u = int'(addr) - 4;
               if (q[u].size() > 0) begin nxt = q[u][0]; t = "R3 R5"; end
               else t = "R6";
            end else t = "R2";
         end
         if (wr_en && addr == 3'd0) begin
            for (int k = 0; k < NU; k++) begin
               msel[k] = int'(wdata[k*5 +: 5]); q[k].delete(); movf[k] = 1'b0;
            end
         end else begin
            for (int k = 0; k < NU; k++) begin
               int sz;
               sz = q[k].size();
               if (rd_en && int'(addr) == 4 + k && sz > 0) void'(q[k].pop_front());
               if (edges[msel[k]]) begin
                  if (sz >= DP) movf[k] = 1'b1;
                  else q[k].push_back(ts_in);
               end
            end
         end
         mprev = m2; m2 = m1; m1 = ch_in;
         mrdata = nxt; mtag = t;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (rdata !== mrdata) begin
            errors++;
            $display("FAIL [%s %s] rdata actual=%08h expected=%08h at %0t",
                     mtag, phase, rdata, mrdata, $time);
         end
         ts_in <= ts_in + 32'd3;
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] pack(int a, int b, int c, int d);
      return (32'(d) << 15) | (32'(c) << 10) | (32'(b) << 5) | 32'(a);
   endfunction

   task automatic wr_ctrl(logic [31:0] d);
      wr_en = 1'b1; addr = 3'd0; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a);
      rd_en = 1'b1; addr = 3'(a);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(int c, int hi);
      ch_in[c] = 1'b1;
      repeat (hi) @(negedge clk);
      ch_in[c] = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;                       // R1: reset state read back
      @(negedge clk);
      rd(0); rd(4); rd(1); rd(7);
      @(negedge clk);

      phase = "R4";                       // two units share channel 5
      wr_ctrl(pack(5, 5, 31, 0));
      pulse(5, 4); pulse(31, 3); pulse(5, 6);
      rd(4); rd(5); rd(6); rd(4); rd(5); rd(6); rd(7);

      phase = "R6";
      rd(4); rd(4); rd(5);
      @(negedge clk);

      phase = "R7";                       // overflow of unit 3 on channel 0
      for (int i = 0; i < DP + 2; i++) pulse(0, 3);
      rd(0);
      rd(7); rd(0); rd(7); rd(7); rd(7); rd(7); rd(0);
      for (int i = 0; i < DP; i++) pulse(0, 3);
      ch_in[0] = 1'b1;                    // event arrives while popping a full FIFO
      repeat (2) @(negedge clk);
      rd(7);
      ch_in[0] = 1'b0;
      repeat (3) @(negedge clk);
      rd(0);

      phase = "R8";                       // control write clears all units
      pulse(5, 3);
      wr_ctrl(pack(5, 6, 31, 0));
      rd(0); rd(4); rd(7);
      ch_in[6] = 1'b1;                    // edge lands with a control write
      @(negedge clk); @(negedge clk);
      wr_ctrl(pack(5, 6, 31, 0));
      ch_in[6] = 1'b0;
      repeat (3) @(negedge clk);
      rd(5);

      phase = "R9";                       // switch onto a channel already high
      ch_in[10] = 1'b1;
      repeat (5) @(negedge clk);
      wr_ctrl(pack(10, 10, 10, 10));
      repeat (5) @(negedge clk);
      rd(4); rd(5); rd(6); rd(7);
      ch_in[10] = 1'b0;
      repeat (3) @(negedge clk);

      phase = "R3";                       // randomised mix
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(3) == 0) ch_in[$urandom_range(31)] ^= 1'b1;
         wr_en = ($urandom_range(150) == 0);
         rd_en = ($urandom_range(3) == 0);
         addr  = 3'($urandom_range(7));
         wdata = $urandom;
         if (wr_en && $urandom_range(1) == 0) addr = 3'd0;
         if (i % 600 == 0) begin wr_en = 1'b1; addr = 3'd0; wdata = pack(1, 1, 2, 3); end
         @(negedge clk);
      end
      wr_en = 1'b0; rd_en = 1'b0;
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL [watchdog] run actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule